// File: doc/BRIEF.md
# Transmit Holding-Register-Empty Interrupt Generator

This block decides when a 16-deep transmit FIFO counts as empty and when that condition raises the transmit interrupt request of a 16550-style serial port. It watches the FIFO occupancy that the FIFO logic supplies. When the FIFO drains after holding only one byte at a time, the block holds back the empty flag. The wait is one character time less the final stop bit, counted in 16x baud ticks. This keeps the interrupt from firing while the serializer is still busy with the last byte. If the FIFO has held two or more bytes at once since the last empty, the flag rises at once.

The request is latched when the empty flag rises. It is also latched when the FIFO-mode enable bit changes while the FIFO is empty. A CPU write to the holding register clears the request, and so does an acknowledge from a read of the interrupt identification register. The transmit interrupt enable masks only the request pin, and the empty flag keeps following the FIFO. The FIFO storage, the serializer and the interrupt priority encoder sit outside this block.

Top module: `txe_irq_gen`

## Requirements
- R1: After reset, `thre` is 1 and `tx_irq` is 0.
- R2: In the cycle after a clock edge that samples `occ` non-zero, `thre` is 0, and any delay count in progress is discarded.
- R3: A sticky "multi" flag sets at an edge that samples `occ` >= 2 and clears when `thre` rises. When the flag is set and the FIFO is empty, `thre` rises one cycle after `occ` is first sampled as 0.
- R4: In FIFO mode (`fifo_en`=1) with the multi flag clear, `thre` rises at the edge that samples the N-th `baud_tick` while empty, where N = (`frame_bits` - 1) * 16. Values of `frame_bits` below 2 are treated as 2.
- R5: If `occ` becomes non-zero before the delay ends, `thre` stays 0. The count restarts from zero at the next empty.
- R6: An edge that samples `fifo_en_chg`=1 with `occ`=0 sets `thre` with no delay and sets the pending request, even if `thre` was already 1.
- R7: With `fifo_en`=0, `thre` rises one cycle after `occ` is sampled as 0, with no delay.
- R8: The pending request sets at every rising edge of `thre`, and `tx_irq` equals pending AND `tx_ie`.
- R9: An edge that samples `thr_wr` or `iir_rd_ack` clears the pending request. A set event at the same edge wins.
- R10: While `tx_ie`=0, `tx_irq` stays 0 but `thre` keeps updating. Setting `tx_ie` while a request is pending drives `tx_irq` to 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| occ | input | CW (5) | Transmit FIFO occupancy, 0..DEPTH |
| thr_wr | input | 1 | CPU write strobe to the holding register |
| iir_rd_ack | input | 1 | Identification-register read reporting this source |
| fifo_en | input | 1 | FIFO mode enable |
| fifo_en_chg | input | 1 | One-cycle pulse when the FIFO enable bit changes |
| tx_ie | input | 1 | Transmit interrupt enable |
| baud_tick | input | 1 | 16x baud-rate tick |
| frame_bits | input | FW (4) | Bits per frame, start to last stop bit |
| thre | output | 1 | Transmit holding-register-empty status |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its defaults, DEPTH=16 and FW=4, so the occupancy runs from 0 to 16 and frame lengths up to 15 bits can be set. It uses frame lengths of 2, 7, 10 and 12 bits, which makes the delay 16, 96, 144 and 176 ticks. The tick arrives every other clock, so each delay is long enough for an abort write to land in the middle of it. Scenarios fill the FIFO all the way to 16 to set the multi flag, toggle FIFO mode while a delay is in progress, and mask the enable while a request is pending.

// File: rtl/txe_pkg.sv
package txe_pkg;
  // Baud ticks per serial bit period.
  localparam int TICKS_PER_BIT = 16;
  localparam int TPB_SHIFT     = $clog2(TICKS_PER_BIT);
endpackage

// File: rtl/txe_mix_track.sv
module txe_mix_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ge2,
  input  logic clr,
  output logic multi
);
  logic multi_q, multi_d;

  always_comb begin
    multi_d = multi_q;
    if (clr)      multi_d = 1'b0;
    else if (ge2) multi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) multi_q <= 1'b0;
    else        multi_q <= multi_d;
  end

  assign multi = multi_q;

  a_r3_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ge2 && !clr) |=> multi_q);
  a_r3_clear_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !multi_q);
endmodule

// File: rtl/txe_dly_timer.sv
module txe_dly_timer
  import txe_pkg::*;
#(
  parameter int FW = 4,
  localparam int TW = FW + TPB_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [FW-1:0] frame_bits,
  output logic          expire
);
  logic [FW-1:0] frame_eff;
  logic [TW-1:0] limit;
  logic [TW-1:0] cnt_q, cnt_d;

  // Frame length less one stop bit, scaled to ticks.
  always_comb begin
    frame_eff = (frame_bits < FW'(2)) ? FW'(2) : frame_bits;
    limit     = {frame_eff - FW'(1), {TPB_SHIFT{1'b0}}};
  end

  assign expire = run && tick && (cnt_q == limit - TW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (expire) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
  a_r5_restart_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/txe_req_latch.sv
module txe_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic irq
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (set)      pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq = pend_q && en;

  a_r8_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend_q);
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pend_q);
endmodule

// File: rtl/txe_irq_gen.sv
module txe_irq_gen #(
  parameter int DEPTH = 16,
  parameter int FW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  input  logic          thr_wr,
  input  logic          iir_rd_ack,
  input  logic          fifo_en,
  input  logic          fifo_en_chg,
  input  logic          tx_ie,
  input  logic          baud_tick,
  input  logic [FW-1:0] frame_bits,
  output logic          thre,
  output logic          tx_irq
);
  logic empty_now;
  logic thre_q, thre_d;
  logic multi;
  logic bypass;
  logic run;
  logic expire;
  logic rise;
  logic req_set;

  assign empty_now = (occ == '0);
  // Immediate path: mode change, non-FIFO mode, or several bytes were queued.
  assign bypass    = fifo_en_chg || !fifo_en || multi;
  assign run       = empty_now && !thre_q && !bypass;

  always_comb begin
    thre_d = thre_q;
    if (!empty_now)  thre_d = 1'b0;
    else if (thre_q) thre_d = 1'b1;
    else if (bypass) thre_d = 1'b1;
    else if (expire) thre_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thre_q <= 1'b1;
    else        thre_q <= thre_d;
  end

  assign rise    = thre_d && !thre_q;
  assign req_set = rise || (fifo_en_chg && empty_now);

  txe_mix_track u_mix (
    .clk   (clk),
    .rst_n (rst_n),
    .ge2   (occ >= CW'(2)),
    .clr   (rise),
    .multi (multi)
  );

  txe_dly_timer #(.FW(FW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (baud_tick),
    .frame_bits (frame_bits),
    .expire     (expire)
  );

  txe_req_latch u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (req_set),
    .clr   (thr_wr || iir_rd_ack),
    .en    (tx_ie),
    .irq   (tx_irq)
  );

  assign thre = thre_q;

  a_r2_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_now |=> !thre);
  a_r3_fast_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_now && multi) |=> thre);
  a_r6_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_chg && empty_now) |=> (thre && (tx_irq == tx_ie)));
  a_r7_no_fifo_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_now && !fifo_en) |=> thre);
  a_r8_rise_requests: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thre) |-> (tx_irq == tx_ie));
endmodule

// File: tb/txe_irq_gen_tb.sv
`timescale 1ns/1ps
module txe_irq_gen_tb;
  localparam int DEPTH = 16;
  localparam int FW    = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] occ = '0;
  logic          thr_wr = 1'b0, iir_rd_ack = 1'b0;
  logic          fifo_en = 1'b1, fifo_en_chg = 1'b0, tx_ie = 1'b1;
  logic          baud_tick = 1'b0;
  logic [FW-1:0] frame_bits = 4'd10;
  logic          thre, tx_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur = "R1";

  // reference model state
  bit m_thre, m_multi, m_pend;
  int m_ticks;

  always #10 clk = ~clk;

  txe_irq_gen #(.DEPTH(DEPTH), .FW(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .occ(occ), .thr_wr(thr_wr), .iir_rd_ack(iir_rd_ack),
    .fifo_en(fifo_en), .fifo_en_chg(fifo_en_chg), .tx_ie(tx_ie), .baud_tick(baud_tick),
    .frame_bits(frame_bits), .thre(thre), .tx_irq(tx_irq));

  // tick every other clock
  int tdiv = 0;
  always @(posedge clk) begin
    #2;
    tdiv = (tdiv + 1) % 2;
    baud_tick = (tdiv == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thre = 1; m_multi = 0; m_pend = 0; m_ticks = 0;
    end else begin
      bit nthre, up, setev;
      int fe, lim;
      fe  = (frame_bits < 2) ? 2 : int'(frame_bits);
      lim = (fe - 1) * 16;
      nthre = m_thre;
      if (occ != 0) begin nthre = 0; m_ticks = 0; end
      else if (m_thre) begin nthre = 1; m_ticks = 0; end
      else if (fifo_en_chg || !fifo_en || m_multi) begin nthre = 1; m_ticks = 0; end
      else if (baud_tick) begin
        m_ticks++;
        if (m_ticks >= lim) begin nthre = 1; m_ticks = 0; end
      end
      up    = nthre && !m_thre;
      setev = up || (fifo_en_chg && occ == 0);
      if (up) m_multi = 0; else if (occ >= 2) m_multi = 1;
      if (setev) m_pend = 1; else if (thr_wr || iir_rd_ack) m_pend = 0;
      m_thre = nthre;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare with the model on every clock
  always @(negedge clk) if (rst_n && !done) begin
    check(thre === m_thre, {cur, " thre"}, thre, m_thre);
    check(tx_irq === (m_pend && tx_ie), {cur, " tx_irq"}, tx_irq, m_pend && tx_ie);
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic push(input int k);
    for (int i = 0; i < k; i++) begin
      thr_wr = 1; occ = occ + 1'b1; cyc(); thr_wr = 0;
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin @(posedge clk); if (baud_tick) k++; end
    #2;
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    cyc(3);
    @(negedge clk);
    check(thre === 1'b1, "R1 reset thre", thre, 1);
    check(tx_irq === 1'b0, "R1 reset irq", tx_irq, 0);
    cyc(); rst_n = 1; cyc(2);

    // R2 + R4: single byte, delayed empty, 144 ticks
    cur = "R4";
    push(1);
    @(negedge clk); check(thre === 1'b0, "R2 busy", thre, 0);
    cyc(3); occ = 0;
    wait_ticks(143); @(negedge clk);
    check(thre === 1'b0, "R4 before delay", thre, 0);
    wait_ticks(1); @(negedge clk);
    check(thre === 1'b1, "R4 at delay", thre, 1);
    check(tx_irq === 1'b1, "R8 irq on rise", tx_irq, 1);
    // R9 ack clears
    cur = "R9"; cyc(); iir_rd_ack = 1; cyc(); iir_rd_ack = 0;
    @(negedge clk); check(tx_irq === 1'b0, "R9 ack clears", tx_irq, 0);

    // R3: fill to full, drain -> immediate
    cur = "R3";
    push(16); cyc(2);
    for (int i = 0; i < 16; i++) begin occ = occ - 1'b1; cyc(2); end
    @(negedge clk);
    check(thre === 1'b1, "R3 immediate", thre, 1);

    // R5: abort by write during delay
    cur = "R5"; frame_bits = 4'd7;
    push(1); cyc(2); occ = 0;
    wait_ticks(40); push(1);
    @(negedge clk); check(thre === 1'b0, "R5 aborted", thre, 0);
    cyc(2); occ = 0; wait_ticks(95); @(negedge clk);
    check(thre === 1'b0, "R5 restart full", thre, 0);
    wait_ticks(1); @(negedge clk);
    check(thre === 1'b1, "R5 expire", thre, 1);

    // R9: write clears, and set-wins on same edge via mode change
    cur = "R9"; thr_wr = 1; fifo_en_chg = 1; cyc(); thr_wr = 0; fifo_en_chg = 0;
    @(negedge clk); check(tx_irq === 1'b1, "R9 set wins", tx_irq, 1);
    thr_wr = 1; cyc(); thr_wr = 0;
    @(negedge clk); check(tx_irq === 1'b0, "R9 write clears", tx_irq, 0);

    // R6: mode change during delay -> immediate
    cur = "R6"; frame_bits = 4'd12;
    push(1); cyc(2); occ = 0; wait_ticks(30);
    fifo_en_chg = 1; fifo_en = 0; cyc(); fifo_en_chg = 0;
    @(negedge clk);
    check(thre === 1'b1, "R6 thre", thre, 1);
    check(tx_irq === 1'b1, "R6 irq", tx_irq, 1);

    // R7: non-FIFO mode immediate
    cur = "R7"; iir_rd_ack = 1; push(1); iir_rd_ack = 0; cyc(2); occ = 0; cyc();
    @(negedge clk); check(thre === 1'b1, "R7 immediate", thre, 1);
    fifo_en = 1; fifo_en_chg = 1; cyc(); fifo_en_chg = 0; iir_rd_ack = 1; cyc(); iir_rd_ack = 0;

    // R10: masked request, status updates
    cur = "R10"; tx_ie = 0; frame_bits = 4'd1;
    push(1); cyc(2); occ = 0; wait_ticks(16); @(negedge clk);
    check(thre === 1'b1, "R10 status runs", thre, 1);
    check(tx_irq === 1'b0, "R10 masked", tx_irq, 0);
    cyc(); tx_ie = 1; #1;
    check(tx_irq === 1'b1, "R10 unmask", tx_irq, 1);
    cyc(5);
    finish_run();
  end
endmodule